// File: doc/BRIEF.md
# Programmable SPI Flash Command Shifter

This block sends one arbitrary command to a serial NOR flash and collects the bytes that come back. Software loads up to six outgoing bytes into a small transmit window, writes the total number of bits to send and receive, and then sets the start bit in the command register. The engine lowers chip select and shifts the bits out on MOSI, most significant bit first, in single-bit SPI mode 0. At the same time it shifts every MISO sample into a 64-bit receive bank. When the programmed bit count has gone out, it raises chip select and clears the start bit by itself.

The register port is one byte wide, and reads of it are combinational. An opcode with no address and no data needs only a bit count of 8. A register read with opcode plus N reply bytes uses 8·(1+N) bits, and the reply bytes are read back from the receive registers. The serial clock is the system clock divided by four. Chip select stays high for at least two serial clock periods between transfers.

Top module: `spi_cmd_shifter`

## Requirements
- R1: After reset, chip select is high, SCK and MOSI are low, and every register reads 0. The address map is: 0 command, 1 bit count, 2..7 transmit bytes 0..5, 8..15 receive bytes 0..7.
- R2: Bits go out MSB first. Transmit byte 5 goes first, then byte 4, and so on down to byte 0. Any bit positions beyond those 48 bits drive 0 on MOSI.
- R3: The receive bank is a 64-bit shift register that takes one MISO sample per bit. Receive byte k holds bits 8k+7..8k, so after a transfer that ends with N reply bytes, the first reply byte sits in receive byte N-1 and the last in receive byte 0.
- R4: Writing 1 to command bit 2 starts a transfer. Command bit 2 reads 1 while the engine is busy and returns to 0 by itself when chip select rises. All other command bits read 0.
- R5: The transfer lasts exactly min(count, 64) bit times, with one SCK rising edge per bit.
- R6: The link runs in SPI mode 0. SCK idles low, SCK runs at the system clock divided by 4, MOSI changes only while SCK is low, and MISO is sampled on the rising edge of SCK.
- R7: A start written while the engine is busy is ignored. The transfer already in progress keeps its length, and no second transfer follows.
- R8: Between two transfers, chip select stays high for at least 8 system clocks, which is two SCK periods.
- R9: A start with a bit count of 0 never lowers chip select. Command bit 2 reads 1 for exactly one cycle after the write and then reads 0.
- R10: Writing command bit 7 together with the start bit does not change the busy reporting. The command register reads 0x04 while that transfer is busy.
- R11: The receive registers ignore writes and change only while a transfer is shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions assume that MISO is driven by a mode-0 device, that is, it changes only on falling SCK or when chip select falls. They also assume that software may write the start bit at any time, including back to back with the end of a transfer. The stimulus meets the first assumption with a bench slave that updates MISO on those edges only. It tests the second by issuing starts while the engine is busy, starts with a zero count, and a start in the cycles just after chip select rises, so that the gap rule and the ignored-start rule are both exercised.

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int GAP_CLKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int GW = $clog2(GAP_CLKS + 1);

  typedef enum logic [1:0] {S_IDLE, S_ZERO, S_PEND, S_RUN} st_t;

  st_t             state;
  logic [7:0]      cnt_q;
  logic [5:0][7:0] txr;
  logic [63:0]     tx_sh, rx_q;
  logic [1:0]      ph;
  logic [6:0]      bitn, len;
  logic [GW-1:0]   gap;

  wire       busy    = state != S_IDLE;
  wire       trig    = reg_wr && reg_addr == 4'd0 && reg_wdata[2];
  wire [6:0] eff_len = cnt_q > 8'd64 ? 7'd64 : cnt_q[6:0];
  wire [2:0] tx_idx  = 3'(reg_addr - 4'd2);
  wire       run     = state == S_RUN;

  assign spi_cs_n = ~run;
  assign spi_sck  = run & ph[1];
  assign spi_mosi = run & tx_sh[63];

  always_comb begin
    case (reg_addr)
      4'd0:                         reg_rdata = {5'b0, busy, 2'b0};
      4'd1:                         reg_rdata = cnt_q;
      4'd2, 4'd3, 4'd4, 4'd5, 4'd6,
      4'd7:                         reg_rdata = txr[tx_idx];
      default:                      reg_rdata = rx_q[{reg_addr[2:0], 3'b000} +: 8];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt_q <= '0;
      txr   <= '0;
      tx_sh <= '0;
      rx_q  <= '0;
      ph    <= '0;
      bitn  <= '0;
      len   <= '0;
      gap   <= '0;
    end else begin
      if (reg_wr && reg_addr == 4'd1) cnt_q <= reg_wdata;
      if (reg_wr && reg_addr >= 4'd2 && reg_addr <= 4'd7) txr[tx_idx] <= reg_wdata;
      if (gap != '0) gap <= gap - 1'b1;
      case (state)
        S_IDLE: if (trig) begin
          len   <= eff_len;
          state <= (eff_len == 7'd0) ? S_ZERO : S_PEND;
        end
        S_ZERO: state <= S_IDLE;
        S_PEND: if (gap == '0) begin
          state <= S_RUN;
          ph    <= '0;
          bitn  <= '0;
          tx_sh <= {txr, 16'h0000};
        end
        S_RUN: begin
          ph <= ph + 2'd1;
          if (ph == 2'd1) rx_q <= {rx_q[62:0], spi_miso};
          if (ph == 2'd3) begin
            tx_sh <= {tx_sh[62:0], 1'b0};
            bitn  <= bitn + 7'd1;
            if (bitn == len - 7'd1) begin
              state <= S_IDLE;
              gap   <= GW'(GAP_CLKS);
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [3:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_cnt <= 4'hf;
    else if (!spi_cs_n) hi_cnt <= '0;
    else if (hi_cnt != 4'hf) hi_cnt <= hi_cnt + 4'd1;
  end

  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(hi_cnt) >= 4'(GAP_CLKS)); // R8
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(rx_q)); // R11
  AST_BUSY_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    busy && trig |=> $stable(len)); // R7
  AST_ZERO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_ZERO |=> !busy && spi_cs_n); // R9
  AST_MOSI_LOW_SCK: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n && !$stable(spi_mosi) && !$fell(spi_cs_n) |-> !spi_sck); // R6
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck && !spi_mosi); // R6
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> len <= 7'd64 && len != 7'd0); // R5
endmodule

// File: tb/spi_cmd_shifter_tb.sv
module spi_cmd_shifter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, reg_wr = 0, spi_miso = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic spi_sck, spi_cs_n, spi_mosi;

  spi_cmd_shifter dut_i (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
                         .spi_sck, .spi_cs_n, .spi_mosi, .spi_miso);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int sck_rises = 0, cs_falls = 0, hi_run = 0, last_gap = 0, mi = 63;
  bit done = 0;
  logic [63:0] pat = 0, rx_model = 0;
  logic exp_q[$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: each SCK rise must match the next expected MOSI bit (R2, R5, R6)
  always @(posedge spi_sck) begin
    sck_rises++;
    if (exp_q.size() == 0) check(0, "R5 extra SCK bit", 1, 0);
    else begin
      automatic logic e = exp_q.pop_front();
      check(spi_mosi == e, "R2 MOSI bit", spi_mosi, e);
    end
  end

  // mode-0 slave: MISO updates when CS falls and on each falling SCK
  always @(negedge spi_cs_n) begin cs_falls++; mi = 63; spi_miso = pat[63]; end
  always @(negedge spi_sck) if (!spi_cs_n && mi > 0) begin mi--; spi_miso = pat[mi]; end

  always @(negedge clk) begin
    if (spi_cs_n) hi_run++;
    else begin if (hi_run != 0) last_gap = hi_run; hi_run = 0; end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    do rd(4'd0, c); while (c[2]);
  endtask

  task automatic check_rx(input string req);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) begin
      rd(4'(8 + k), v);
      check(v == rx_model[8*k +: 8], req, v, rx_model[8*k +: 8]);
    end
  endtask

  // driver: programs a transfer and pushes the expected MOSI bits
  task automatic run_xfer(input logic [47:0] txv, input logic [7:0] cnt, input logic [63:0] p,
                          input logic [7:0] cmd, input bit poke, input string req);
    int n;
    logic [63:0] txw;
    n = (cnt > 64) ? 64 : cnt;
    txw = {txv, 16'h0};
    for (int k = 0; k < 6; k++) wr(4'(2 + k), txv[8*k +: 8]);
    wr(4'd1, cnt);
    pat = p;
    sck_rises = 0; cs_falls = 0;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(txw[63 - i]);
      rx_model = {rx_model[62:0], p[63 - i]};
    end
    wr(4'd0, cmd);
    if (poke) begin wr(4'd1, 8'd8); wr(4'd0, 8'h04); end
    wait_idle();
    repeat (12) @(negedge clk);
    check(sck_rises == n, {req, " bit count"}, sck_rises, n);
    check(exp_q.size() == 0, {req, " all bits sent"}, exp_q.size(), 0);
    check(cs_falls == 1, {req, " one CS assertion"}, cs_falls, 1);
    check_rx({req, " R3 receive bank"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check(spi_cs_n && !spi_sck && !spi_mosi, "R1 pins", {spi_cs_n, spi_sck, spi_mosi}, 3'b100);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      check(v == 0, "R1 register reset", v, 0);
    end
    // R2/R3/R6: ID read, opcode then 3 reply bytes
    run_xfer(48'h9F00_0000_0000, 8'd32, 64'hC2_20_18_55_0000_0000, 8'h04, 0, "R2 R6 id read");
    // opcode + 3 address bytes + 2 reply bytes
    run_xfer(48'h0312_3456_0000, 8'd48, 64'hA5A5_A5A5_1234_0000, 8'h04, 0, "R3 addr read");
    // full 64 bits, all six transmit bytes and zero fill
    run_xfer(48'hDEAD_BEEF_CAFE, 8'd64, 64'h0123_4567_89AB_CDEF, 8'h04, 0, "R2 full window");
    // R5 clamp above 64
    run_xfer(48'h5A5A_5A5A_5A5A, 8'd70, 64'hFEDC_BA98_7654_3210, 8'h04, 0, "R5 clamp");
    // R5 non byte multiple
    run_xfer(48'hB700_0000_0000, 8'd12, 64'hF0F0_0000_0000_0000, 8'h04, 0, "R5 twelve bits");
    // R7 start while busy ignored
    run_xfer(48'h1122_3344_5566, 8'd64, 64'h8000_0000_0000_0001, 8'h04, 1, "R7 busy start");
    // R10 bit 7 with start
    for (int k = 0; k < 6; k++) wr(4'(2 + k), 8'h00);
    wr(4'd1, 8'd16);
    pat = 64'hFFFF_0000_0000_0000;
    for (int i = 0; i < 16; i++) begin
      exp_q.push_back(1'b0);
      rx_model = {rx_model[62:0], 1'b1};
    end
    wr(4'd0, 8'h84);
    rd(4'd0, v);
    check(v == 8'h04, "R10 busy readback", v, 8'h04);
    wait_idle();
    rd(4'd0, v);
    check(v == 8'h00, "R4 start bit self-clears", v, 0);
    // R8 back-to-back start right after CS rises
    wr(4'd1, 8'd8);
    wr(4'd7, 8'h06);
    for (int i = 0; i < 8; i++) exp_q.push_back(8'h06 >> (7 - i));
    for (int i = 0; i < 8; i++) rx_model = {rx_model[62:0], 1'b0};
    pat = 0;
    wr(4'd0, 8'h04);
    @(posedge spi_cs_n);
    for (int i = 0; i < 8; i++) exp_q.push_back(8'h06 >> (7 - i));
    for (int i = 0; i < 8; i++) rx_model = {rx_model[62:0], 1'b0};
    wr(4'd0, 8'h04);
    wait_idle();
    repeat (4) @(negedge clk);
    check(last_gap >= 8, "R8 CS high gap", last_gap, 8);
    // R9 zero count
    repeat (12) @(negedge clk);
    wr(4'd1, 8'd0);
    cs_falls = 0;
    wr(4'd0, 8'h04);
    #1 check(reg_rdata[2] == 1'b1, "R9 busy one cycle", reg_rdata, 8'h04);
    @(negedge clk); #1;
    check(reg_rdata == 8'h00, "R9 clears next clock", reg_rdata, 0);
    repeat (10) @(negedge clk);
    check(cs_falls == 0, "R9 CS stays high", cs_falls, 0);
    // R11 writes to receive registers ignored
    for (int k = 0; k < 8; k++) wr(4'(8 + k), 8'hEE);
    check_rx("R11 receive write ignored");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule